// File: doc/BRIEF.md
# Processor bus cycle sequencer

This block produces the external bus timing of one processor machine cycle. It runs on the oscillator clock. Each T-state of the derived system clock spans two oscillator clocks, a first half and a second half. The core side presents a request with a cycle kind, an address and write data. The request is taken when `ready_o` is high.

The sequencer then steps through T1, T2, any wait states and T3. It drives the address, the active-low memory-request, I/O-request, read, write and opcode-fetch strobes, and the write data with its enable. A purely internal cycle lasts one T-state and drives no strobe. Read data is captured in the middle of T3. It is returned with a one-clock done pulse in the last half of the cycle.

A new request can be taken in that last half, so cycles follow each other with no idle gap.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst_ni` is low, all five strobes are high, `done_o` and `data_oe_o` are low and `ready_o` is high.
- R2: A bus cycle with no wait states lasts six clocks (T1, T2 and T3, two halves each), counted from the clock after acceptance. `ready_o` is high only in the final half, and a request taken there starts T1 on the next clock.
- R3: Kind codes 5, 6 and 7 run an internal cycle of two clocks (T1 only) with every strobe high and `done_o` in the second clock.
- R4: `wait_ni` is sampled at the end of the second half of T2 and of each wait state. Each low sample inserts one wait state of two clocks before T3.
- R5: Kind 0 (opcode fetch) drives `m1_no` low for the whole cycle. It drives `mreq_no` and `rd_no` low from the second half of T1 to the end of T3.
- R6: Kind 1 (memory read) drives `mreq_no` and `rd_no` as in R5, with `m1_no` high.
- R7: Kind 2 (memory write) drives `mreq_no` low from the second half of T1 to the end of T3. It drives `wr_no` low from the start of T2 until the second half of T3. `data_oe_o` is high and `data_o` carries the write data for the whole cycle.
- R8: Kind 3 (I/O read) drives `iorq_no` and `rd_no` low from the second half of T1 to the end of T3.
- R9: Kind 4 (I/O write) drives `iorq_no` and `wr_no` low from the second half of T1. `wr_no` rises at the second half of T3, and `iorq_no` rises at the end of T3. `data_oe_o` is high for the whole cycle.
- R10: `addr_o` holds the accepted address for every clock of the cycle.
- R11: `rdata_i` is captured at the end of the first half of T3. `rdata_o` shows it in the final half. `done_o` is high for exactly one clock, the final half of each cycle.
- R12: A request raised while `ready_o` is low is ignored. The running cycle's address, strobes and length are unchanged, and the bus returns to idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request from the core |
| kind_i | input | 3 | Cycle kind code |
| addr_i | input | 20 | Access address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Request is accepted this clock |
| wait_ni | input | 1 | Wait request, active low |
| rdata_i | input | 8 | Data bus input |
| addr_o | output | 20 | Address bus |
| data_o | output | 8 | Data bus output |
| data_oe_o | output | 1 | Data bus output enable |
| mreq_no | output | 1 | Memory request strobe, active low |
| iorq_no | output | 1 | I/O request strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| m1_no | output | 1 | Opcode fetch marker, active low |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | Cycle completion pulse |

## Verification
A wrong T-state or a wrong half bit appears at the ports within one clock. A strobe edge moves by one half, a wait state is added or lost, or `done_o` appears in the wrong clock. The bench checks every strobe in every clock of each cycle, so such an error is reported in the clock where it occurs. A wrong capture edge shows as inverted data on `rdata_o` at the done pulse, because the bench holds the correct value on `rdata_i` only across the T3 midpoint. A broken acceptance rule shows as a changed address or a restarted cycle in the next clock.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_INT   = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4
  } tstate_e;

  // all fields active low
  typedef struct packed {
    logic m1;
    logic mreq;
    logic iorq;
    logic rd;
    logic wr;
  } strobe_t;
endpackage

// File: rtl/bus_seq_timing.sv
module bus_seq_timing
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wait_ni,
  output tstate_e           tstate_o,
  output logic              half_o,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ready_o
);
  localparam logic [2:0] LAST_KIND = 3'(K_IOWR);

  tstate_e st_q, st_d;
  logic    half_q, half_d;
  kind_e   kind_q;
  logic    accept;

  assign ready_o = (st_q == TS_IDLE) ||
                   (half_q && ((st_q == TS_T3) || (st_q == TS_T1 && kind_q == K_INT)));
  assign accept  = req_i && ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_IDLE: if (accept) st_d = TS_T1;
      TS_T1: if (half_q) begin
        if (kind_q == K_INT) st_d = accept ? TS_T1 : TS_IDLE;
        else                 st_d = TS_T2;
      end
      TS_T2, TS_TW: if (half_q) st_d = wait_ni ? TS_T3 : TS_TW;
      TS_T3: if (half_q) st_d = accept ? TS_T1 : TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
    half_d = (st_q == TS_IDLE || st_d == TS_IDLE) ? 1'b0 : ~half_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= TS_IDLE;
      half_q  <= 1'b0;
      kind_q  <= K_INT;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      st_q   <= st_d;
      half_q <= half_d;
      if (accept) begin
        kind_q  <= (kind_i > LAST_KIND) ? K_INT : kind_e'(kind_i);
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
    end
  end

  assign tstate_o = st_q;
  assign half_o   = half_q;
  assign kind_o   = kind_q;
endmodule

// File: rtl/bus_seq_strobes.sv
module bus_seq_strobes
  import bus_seq_pkg::*;
(
  input  tstate_e tstate_i,
  input  logic    half_i,
  input  kind_e   kind_i,
  output strobe_t strb_o,
  output logic    data_oe_o,
  output logic    done_o
);
  logic bus, late, wr_mem_win, wr_io_win;

  always_comb begin
    bus        = (tstate_i != TS_IDLE) && (kind_i != K_INT);
    late       = bus && !(tstate_i == TS_T1 && !half_i);
    wr_mem_win = (tstate_i inside {TS_T2, TS_TW}) || (tstate_i == TS_T3 && !half_i);
    wr_io_win  = wr_mem_win || (tstate_i == TS_T1 && half_i);

    strb_o.m1   = !(bus && kind_i == K_FETCH);
    strb_o.mreq = !(late && (kind_i inside {K_FETCH, K_MRD, K_MWR}));
    strb_o.iorq = !(late && (kind_i inside {K_IORD, K_IOWR}));
    strb_o.rd   = !(late && (kind_i inside {K_FETCH, K_MRD, K_IORD}));
    strb_o.wr   = !(bus && ((kind_i == K_MWR && wr_mem_win) ||
                            (kind_i == K_IOWR && wr_io_win)));
    data_oe_o   = bus && (kind_i inside {K_MWR, K_IOWR});
    done_o      = half_i && ((tstate_i == TS_T3) ||
                             (tstate_i == TS_T1 && kind_i == K_INT));
  end
endmodule

// File: rtl/bus_seq_rdcap.sv
module bus_seq_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (cap_i) data_o <= data_i;
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  input  logic              wait_ni,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              mreq_no,
  output logic              iorq_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              m1_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  tstate_e tstate;
  logic    half;
  kind_e   kind;
  strobe_t strb;

  bus_seq_timing #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .kind_i   (kind_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wait_ni  (wait_ni),
    .tstate_o (tstate),
    .half_o   (half),
    .kind_o   (kind),
    .addr_o   (addr_o),
    .wdata_o  (data_o),
    .ready_o  (ready_o)
  );

  bus_seq_strobes u_strobes (
    .tstate_i  (tstate),
    .half_i    (half),
    .kind_i    (kind),
    .strb_o    (strb),
    .data_oe_o (data_oe_o),
    .done_o    (done_o)
  );

  // midpoint of T3: edge closing its first half
  bus_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (tstate == TS_T3 && !half),
    .data_i (rdata_i),
    .data_o (rdata_o)
  );

  assign m1_no   = strb.m1;
  assign mreq_no = strb.mreq;
  assign iorq_no = strb.iorq;
  assign rd_no   = strb.rd;
  assign wr_no   = strb.wr;
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk
  import bus_seq_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    req_i,
  input logic    ready_o,
  input logic    wait_ni,
  input logic    mreq_no,
  input logic    iorq_no,
  input logic    rd_no,
  input logic    wr_no,
  input logic    m1_no,
  input logic    data_oe_o,
  input logic    done_o,
  input tstate_e tstate,
  input logic    half
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tstate == TS_IDLE |-> (mreq_no && iorq_no && rd_no && wr_no && m1_no)); // R1
  AST_SPACE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~mreq_no, ~iorq_no}) <= 1); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no)); // R7
  AST_M1_FETCH_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m1_no |-> (iorq_no && wr_no)); // R5
  AST_WR_DATA_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> data_oe_o); // R7
  AST_WAIT_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tstate == TS_T2 || tstate == TS_TW) && half && !wait_ni) |=> (tstate == TS_TW && !half)); // R4
  AST_WAIT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tstate == TS_T2 || tstate == TS_TW) && half && wait_ni) |=> (tstate == TS_T3 && !half)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && req_i && ready_o) |=> (tstate == TS_T1 && !half)); // R2
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ready_o   (ready_o),
  .wait_ni   (wait_ni),
  .mreq_no   (mreq_no),
  .iorq_no   (iorq_no),
  .rd_no     (rd_no),
  .wr_no     (wr_no),
  .m1_no     (m1_no),
  .data_oe_o (data_oe_o),
  .done_o    (done_o),
  .tstate    (tstate),
  .half      (half)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic [19:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wait_ni = 1'b1;
  logic [7:0]  rdata_i = '0;
  logic        ready_o, data_oe_o, mreq_no, iorq_no, rd_no, wr_no, m1_no, done_o;
  logic [19:0] addr_o;
  logic [7:0]  data_o, rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  bus_cycle_seq u_bus_cycle_seq (.*);

  // {kind, waits, addr, wdata, rdata}
  localparam int NV = 9;
  localparam logic [42:0] VEC [NV] = '{
    {3'd0, 4'd0, 20'h00100, 8'h00, 8'h3E},
    {3'd1, 4'd1, 20'hABCDE, 8'h00, 8'hA5},
    {3'd2, 4'd0, 20'h12345, 8'h5A, 8'h00},
    {3'd3, 4'd2, 20'h000FE, 8'h00, 8'hC3},
    {3'd4, 4'd1, 20'h00042, 8'h99, 8'h00},
    {3'd5, 4'd0, 20'h0F0F0, 8'h00, 8'h00},
    {3'd6, 4'd0, 20'h70707, 8'h00, 8'h00},
    {3'd0, 4'd3, 20'hFFFFF, 8'h00, 8'h81},
    {3'd2, 4'd2, 20'h80000, 8'hE7, 8'h00}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic string tag(input logic [2:0] k);
    case (k)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R3";
    endcase
  endfunction

  // {m1, mreq, iorq, rd, wr}, active low, for half j of a cycle of length tot
  function automatic logic [4:0] exp_strb(input logic [2:0] k, input int j, input int tot);
    bit late = (j >= 1);
    bit wm = (j >= 2) && (j <= tot - 2);
    bit wi = (j >= 1) && (j <= tot - 2);
    logic [4:0] s = 5'h1F;
    case (k)
      3'd0: begin s[4] = 1'b0; s[3] = !late; s[1] = !late; end
      3'd1: begin s[3] = !late; s[1] = !late; end
      3'd2: begin s[3] = !late; s[0] = !wm; end
      3'd3: begin s[2] = !late; s[1] = !late; end
      3'd4: begin s[2] = !late; s[0] = !wi; end
      default: s = 5'h1F;
    endcase
    return s;
  endfunction

  task automatic run_cyc(input logic [2:0] k, input logic [19:0] a, input logic [7:0] wd,
                         input logic [7:0] rdv, input int nw, input bit issued,
                         input bit chain, input logic [2:0] nk, input logic [19:0] na,
                         input logic [7:0] nwd, input bit noise);
    bit is_int = (k >= 3'd5);
    bit is_wr = (k == 3'd2) || (k == 3'd4);
    bit is_rd = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    int tot = is_int ? 2 : 6 + 2 * nw;
    if (!issued) begin
      @(negedge clk_i);
      req_i = 1'b1; kind_i = k; addr_i = a; wdata_i = wd;
    end
    rdata_i = ~rdv;
    for (int j = 0; j < tot; j++) begin
      @(negedge clk_i);
      chk(tag(k), {27'd0, m1_no, mreq_no, iorq_no, rd_no, wr_no}, {27'd0, exp_strb(k, j, tot)});
      chk(noise ? "R12" : "R10", {12'd0, addr_o}, {12'd0, a});
      chk(tag(k), {31'd0, data_oe_o}, {31'd0, is_wr});
      if (is_wr) chk("R7", {24'd0, data_o}, {24'd0, wd});
      chk("R11", {31'd0, done_o}, {31'd0, j == tot - 1});
      chk(nw > 0 ? "R4" : "R2", {31'd0, ready_o}, {31'd0, j == tot - 1});
      if (is_rd && j == tot - 1) chk("R11", {24'd0, rdata_o}, {24'd0, rdv});
      wait_ni = !((j >= 3) && (j < 3 + 2 * nw) && ((j - 3) % 2 == 0));
      rdata_i = (j == tot - 2) ? rdv : ~rdv;
      if (j == tot - 1 && chain) begin
        req_i = 1'b1; kind_i = nk; addr_i = na; wdata_i = nwd;
      end else if (noise && j < tot - 1) begin
        req_i = 1'b1; kind_i = 3'd2; addr_i = ~a; wdata_i = ~wd;
      end else begin
        req_i = 1'b0;
      end
    end
    if (!chain) begin
      @(negedge clk_i);
      chk(noise ? "R12" : "R2", {26'd0, m1_no, mreq_no, iorq_no, rd_no, wr_no, done_o},
          {26'd0, 5'h1F, 1'b0});
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a request pending
    req_i = 1'b1; kind_i = 3'd0;
    repeat (3) @(negedge clk_i);
    chk("R1", {27'd0, m1_no, mreq_no, iorq_no, rd_no, wr_no}, {27'd0, 5'h1F});
    chk("R1", {29'd0, done_o, data_oe_o, ready_o}, {29'd0, 3'b001});
    req_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      run_cyc(VEC[v][42:40], VEC[v][35:16], VEC[v][15:8], VEC[v][7:0], int'(VEC[v][39:36]),
              1'b0, 1'b0, 3'd0, 20'd0, 8'd0, 1'b0);
    end

    // R2: back-to-back chain fetch -> write -> internal -> I/O read
    run_cyc(3'd0, 20'h11111, 8'h00, 8'h6C, 0, 1'b0, 1'b1, 3'd2, 20'h22222, 8'h4D, 1'b0);
    run_cyc(3'd2, 20'h22222, 8'h4D, 8'h00, 1, 1'b1, 1'b1, 3'd7, 20'h33333, 8'h00, 1'b0);
    run_cyc(3'd7, 20'h33333, 8'h00, 8'h00, 0, 1'b1, 1'b1, 3'd3, 20'h44444, 8'h00, 1'b0);
    run_cyc(3'd3, 20'h44444, 8'h00, 8'h17, 0, 1'b1, 1'b0, 3'd0, 20'd0, 8'd0, 1'b0);

    // R12: requests while busy are ignored
    run_cyc(3'd1, 20'h5A5A5, 8'h00, 8'hB4, 1, 1'b0, 1'b0, 3'd0, 20'd0, 8'd0, 1'b1);

    // R4: long wait on an I/O write
    run_cyc(3'd4, 20'h00ABC, 8'h3C, 8'h00, 5, 1'b0, 1'b0, 3'd0, 20'd0, 8'd0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule